// File: doc/BRIEF.md
# Write-Through Snooping Data Cache

This block is a small direct-mapped data cache that sits between one processor and a shared memory bus. It keeps one data word per entry, with a valid bit and a tag. A load that hits is answered from the cache one cycle after it is presented. A load that misses requests the bus, waits until the bus is granted and memory reports ready, then fills the entry and returns the fetched word. Every store is sent to memory over the bus. A store also updates the cached word if that word is present. A store to a word that is not cached does not allocate an entry.

The cache also watches write traffic on the shared bus from every other master, processors and I/O processors alike. When another master writes a word that the cache holds, the matching entry is invalidated. The next local load of that word therefore misses and fetches the new value from memory. Each observed write carries a master ID, and writes tagged with this cache's own ID are ignored.

Top module: `snoop_cache`

## Requirements
- R1: After reset, every entry is invalid, `cpu_done` is 0 and `bus_req` is 0, so the first load of any address misses.
- R2: A load miss performs exactly one bus read of that address and returns the word memory supplied. It then fills the entry and marks it valid.
- R3: A load hit raises `cpu_done` one clock edge after the request is sampled, with the cached word on `cpu_rdata`, and starts no bus transaction.
- R4: Every store, hit or miss, performs exactly one bus write with `bus_we`=1 carrying the store's address and data. `cpu_done` follows once the bus completes the write.
- R5: A store to a cached word also updates the cached copy, so a following load hits and returns the stored data.
- R6: A store to a word that is not cached does not allocate an entry: the next load of that word misses.
- R7: An observed bus write from another master that matches a valid entry's index and tag invalidates that entry. The next load of the word misses and returns the new memory value.
- R8: An observed write to the same index but a different tag leaves the held entry valid.
- R9: An observed write whose master ID equals the cache's own ID (parameter `SELF_ID`, default 0) is ignored.
- R10: If a load and an invalidating foreign write to the same address are sampled in the same cycle, the invalidation wins. No hit is reported, and the load completes as a miss with the new data.
- R11: While a bus transfer lacks grant or ready, `bus_req` stays high, `bus_addr` stays stable and `cpu_done` stays low.
- R12: The entry index is `cpu_addr[IDX_W-1:0]` (bits 3:0 by default) and the tag is the remaining upper address bits. Two addresses that differ only in the tag evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load result, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | ADDR_W | Bus transfer address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_rdy | input | 1 | Memory ready; with grant, completes the transfer |
| bus_rdata | input | DATA_W | Bus read data |
| obs_wr | input | 1 | A write is visible on the shared bus |
| obs_addr | input | ADDR_W | Address of the observed write |
| obs_mid | input | MID_W | Master ID of the observed write |

## Verification
The hardest case to reach is R10, where a foreign write lands on exactly the word a load is looking up in the same cycle. The bench first makes the line valid with a load. It then drives the load request and the observed foreign write on the same falling edge. After the next rising edge it checks that no completion pulse appeared, then that the load refetched the new value. Stalled grants, own-ID writes and same-index conflicts are each driven by their own directed task, and a bench-side count of bus reads tells hits from misses.

// File: rtl/snc_pkg.sv
package snc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2
  } snc_state_e;
endpackage

// File: rtl/snc_tag_store.sv
module snc_tag_store #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 4,
  parameter int MID_W   = 2,
  parameter int SELF_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              fill_en,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              obs_wr,
  input  logic [ADDR_W-1:0] obs_addr,
  input  logic [MID_W-1:0]  obs_mid,
  output logic              snp_kill
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  logic              valid_a [DEPTH];
  logic [TAG_W-1:0]  tag_a   [DEPTH];
  logic [DATA_W-1:0] data_a  [DEPTH];

  logic [IDX_W-1:0] l_idx, s_idx, w_idx;
  logic [TAG_W-1:0] l_tag, s_tag, w_tag;
  logic             lk_raw;

  assign l_idx = idx_of(lk_addr);
  assign l_tag = tag_of(lk_addr);
  assign s_idx = idx_of(obs_addr);
  assign s_tag = tag_of(obs_addr);
  assign w_idx = idx_of(wr_addr);
  assign w_tag = tag_of(wr_addr);

  // foreign write that matches a held word
  assign snp_kill = obs_wr && (obs_mid != MID_W'(SELF_ID)) &&
                    valid_a[s_idx] && (tag_a[s_idx] == s_tag);
  assign lk_raw   = valid_a[l_idx] && (tag_a[l_idx] == l_tag);
  // an invalidation of the looked-up entry in this cycle cancels the hit
  assign lk_hit   = lk_raw && !(snp_kill && (s_idx == l_idx));
  assign lk_data  = data_a[l_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] d_q;
    logic              sel_w, sel_s;
    assign sel_w = (w_idx == IDX_W'(g));
    assign sel_s = snp_kill && (s_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else begin
        if (fill_en && sel_w) v_q <= 1'b1;
        if (sel_s)            v_q <= 1'b0;   // invalidate wins over fill
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && sel_w) t_q <= w_tag;
      if ((fill_en || upd_en) && sel_w) d_q <= wr_data;
    end

    assign valid_a[g] = v_q;
    assign tag_a[g]   = t_q;
    assign data_a[g]  = d_q;
  end

  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_kill |=> !valid_a[$past(s_idx)]);                           // R7
  AST_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(snp_kill && s_idx == w_idx)) |=> valid_a[$past(w_idx)]); // R2
  AST_SELF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_mid == MID_W'(SELF_ID)) |-> !snp_kill);                    // R9
endmodule

// File: rtl/snc_ctrl.sv
module snc_ctrl
  import snc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_rdy,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] lk_data,
  output logic              fill_en,
  output logic              upd_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              snp_kill,
  input  logic [ADDR_W-1:0] obs_addr
);
  snc_state_e        state_q;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic              xfer_done, rd_hit_now, take_req;

  assign take_req   = (state_q == ST_IDLE) && cpu_req;
  assign rd_hit_now = take_req && !cpu_we && lk_hit;
  assign xfer_done  = (state_q != ST_IDLE) && bus_gnt && bus_rdy;

  assign lk_addr   = (state_q == ST_IDLE) ? cpu_addr : lat_addr;
  assign bus_req   = (state_q != ST_IDLE);
  assign bus_we    = (state_q == ST_STORE);
  assign bus_addr  = lat_addr;
  assign bus_wdata = lat_wdata;

  assign fill_en = xfer_done && (state_q == ST_FETCH);
  assign upd_en  = xfer_done && (state_q == ST_STORE) && lk_hit;
  assign wr_addr = lat_addr;
  assign wr_data = (state_q == ST_FETCH) ? bus_rdata : lat_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (state_q)
        ST_IDLE: if (cpu_req) begin
          lat_addr  <= cpu_addr;
          lat_wdata <= cpu_wdata;
          if (cpu_we)      state_q <= ST_STORE;
          else if (lk_hit) begin
            cpu_done  <= 1'b1;
            cpu_rdata <= lk_data;
          end else         state_q <= ST_FETCH;
        end
        ST_FETCH: if (xfer_done) begin
          cpu_done  <= 1'b1;
          cpu_rdata <= bus_rdata;
          state_q   <= ST_IDLE;
        end
        ST_STORE: if (xfer_done) begin
          cpu_done <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_STORE_TO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && cpu_we) |=> (bus_req && bus_we));                  // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(bus_gnt && bus_rdy)) |=>
      (bus_req && $stable(bus_addr) && !cpu_done));                 // R11
  AST_NO_STALE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && !cpu_we && snp_kill && obs_addr == cpu_addr) |=> !cpu_done); // R10
  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_now |=> (!bus_req && cpu_done));                         // R3
endmodule

// File: rtl/snoop_cache.sv
module snoop_cache #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 4,
  parameter int MID_W   = 2,
  parameter int SELF_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_rdy,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              obs_wr,
  input  logic [ADDR_W-1:0] obs_addr,
  input  logic [MID_W-1:0]  obs_mid
);
  logic [ADDR_W-1:0] lk_addr, wr_addr;
  logic [DATA_W-1:0] lk_data, wr_data;
  logic              lk_hit, fill_en, upd_en, snp_kill;

  snc_tag_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .MID_W(MID_W), .SELF_ID(SELF_ID)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .fill_en(fill_en), .upd_en(upd_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .obs_wr(obs_wr), .obs_addr(obs_addr), .obs_mid(obs_mid),
    .snp_kill(snp_kill)
  );

  snc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdy(bus_rdy),
    .bus_rdata(bus_rdata),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .fill_en(fill_en), .upd_en(upd_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .snp_kill(snp_kill), .obs_addr(obs_addr)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!bus_req && !cpu_done));                            // R1
endmodule

// File: tb/tb_snoop_cache.sv
`timescale 1ns/1ps
module tb_snoop_cache;
  localparam int AW = 8, DW = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic          cpu_done, bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          bus_gnt, bus_rdy, gnt_en = 1'b1;
  logic          obs_wr = 0;
  logic [AW-1:0] obs_addr = '0;
  logic [1:0]    obs_mid = '0;

  logic [DW-1:0] mem [256];
  int rd_cnt = 0, wr_cnt = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign bus_gnt   = gnt_en;
  assign bus_rdy   = bus_req;
  assign bus_rdata = mem[bus_addr];

  snoop_cache dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_done(cpu_done), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
    .bus_rdy(bus_rdy), .bus_rdata(bus_rdata), .obs_wr(obs_wr),
    .obs_addr(obs_addr), .obs_mid(obs_mid)
  );

  always @(posedge clk) begin
    if (bus_req && bus_gnt && bus_rdy) begin
      if (bus_we) begin
        mem[bus_addr] <= bus_wdata;
        wr_cnt <= wr_cnt + 1;
      end else rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); lat++;
      if (cpu_done) break;
    end
    cpu_req = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                         output int fetches, output int lat);
    int r0 = rd_cnt;
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    wait_done(lat);
    d = cpu_rdata;
    fetches = rd_cnt - r0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] v,
                          output int writes);
    int w0 = wr_cnt, lat;
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = v;
    wait_done(lat);
    cpu_we = 0;
    writes = wr_cnt - w0;
  endtask

  task automatic foreign_write(input logic [AW-1:0] a, input logic [DW-1:0] v,
                               input logic [1:0] mid);
    @(negedge clk);
    obs_wr = 1; obs_addr = a; obs_mid = mid; mem[a] = v;
    @(negedge clk);
    obs_wr = 0;
  endtask

  task automatic t_reset_and_miss();
    logic [DW-1:0] d; int f, l;
    check(cpu_done == 0, "R1 done low", cpu_done, 0);
    check(bus_req == 0, "R1 bus idle", bus_req, 0);
    do_read(8'h25, d, f, l);
    check(f == 1, "R1/R2 cold miss fetch", f, 1);
    check(d == mem[8'h25], "R2 miss data", d, mem[8'h25]);
  endtask

  task automatic t_hit();
    logic [DW-1:0] d; int f, l;
    do_read(8'h25, d, f, l);
    check(f == 0, "R3 hit no bus", f, 0);
    check(l == 1, "R3 hit latency", l, 1);
    check(d == mem[8'h25], "R3 hit data", d, mem[8'h25]);
  endtask

  task automatic t_store_hit();
    logic [DW-1:0] d; int w, f, l;
    do_write(8'h25, 16'h1234, w);
    check(w == 1, "R4 one bus write", w, 1);
    check(mem[8'h25] == 16'h1234, "R4 memory updated", mem[8'h25], 16'h1234);
    do_read(8'h25, d, f, l);
    check(f == 0 && d == 16'h1234, "R5 cached copy updated", d, 16'h1234);
  endtask

  task automatic t_store_miss();
    logic [DW-1:0] d; int w, f, l;
    do_write(8'h47, 16'hBEEF, w);
    check(w == 1, "R4 store miss writes", w, 1);
    do_read(8'h47, d, f, l);
    check(f == 1, "R6 no allocate", f, 1);
    check(d == 16'hBEEF, "R6 data", d, 16'hBEEF);
  endtask

  task automatic t_snoop_kill();
    logic [DW-1:0] d; int f, l;
    foreign_write(8'h25, 16'h5555, 2'd2);
    do_read(8'h25, d, f, l);
    check(f == 1, "R7 invalidated refetch", f, 1);
    check(d == 16'h5555, "R7 new data", d, 16'h5555);
  endtask

  task automatic t_other_tag();
    logic [DW-1:0] d; int f, l;
    foreign_write(8'h35, 16'h0A0A, 2'd3);
    do_read(8'h25, d, f, l);
    check(f == 0, "R8 other tag kept", f, 0);
    do_read(8'h35, d, f, l);
    check(f == 1 && d == 16'h0A0A, "R12 conflict miss", f, 1);
    do_read(8'h25, d, f, l);
    check(f == 1, "R12 evicted by same index", f, 1);
  endtask

  task automatic t_self_id();
    logic [DW-1:0] d; int f, l;
    do_read(8'h60, d, f, l);
    foreign_write(8'h60, mem[8'h60], 2'd0);
    do_read(8'h60, d, f, l);
    check(f == 0, "R9 own ID ignored", f, 0);
  endtask

  task automatic t_collide();
    logic [DW-1:0] d; int f, l, r0;
    r0 = rd_cnt;
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h60;
    obs_wr = 1; obs_addr = 8'h60; obs_mid = 2'd1; mem[8'h60] = 16'h7777;
    @(negedge clk);
    obs_wr = 0;
    check(cpu_done == 0, "R10 no stale hit", cpu_done, 0);
    wait_done(l);
    d = cpu_rdata; f = rd_cnt - r0;
    check(f == 1 && d == 16'h7777, "R10 refetched", d, 16'h7777);
  endtask

  task automatic t_stall();
    logic [DW-1:0] d; int f, l;
    gnt_en = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h81;
    repeat (5) @(negedge clk);
    check(bus_req == 1, "R11 request held", bus_req, 1);
    check(bus_addr == 8'h81, "R11 address stable", bus_addr, 8'h81);
    check(cpu_done == 0, "R11 no completion", cpu_done, 0);
    gnt_en = 1;
    wait_done(l);
    d = cpu_rdata;
    check(d == mem[8'h81], "R11 completes after grant", d, mem[8'h81]);
    do_read(8'h81, d, f, l);
    check(f == 0, "R2 fill valid", f, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hA000 ^ DW'(i * 7);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_and_miss();
    t_hit();
    t_store_hit();
    t_store_miss();
    t_snoop_kill();
    t_other_tag();
    t_self_id();
    t_collide();
    t_stall();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule